// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Responder

This block is the peripheral side of a vectored interrupt. A one-clock pulse on `raise_i` sets a pending flag, and that flag drives the request line `irq_o`. While the request is pending, the block watches the bus for the acknowledge read that the processor issues at the configured level.

The block accepts either of two kinds of evidence for the acknowledge. The first is a CPU-space address pattern on the function code and address lines. The second is a dedicated acknowledge strobe for its own level. When either is seen, the block waits a configurable number of clocks. It then terminates the cycle with a data-size acknowledge and its vector number, placed on the byte lane that matches its port width. If it has no vector, it terminates with an autovector request instead.

When the address and data strobes negate, the block releases every output and clears the pending flag. Bus outputs are driven only while a cycle is selected. Outside a cycle they are gated off and held at zero, and the enables tell the pad logic when to drive.

Top module: `iack_responder`

## Requirements
- R1: One clock after `raise_i` is sampled high, `irq_o` is 1. It stays 1 until an acknowledge cycle completes.
- R2: A cycle is selected when all of the following hold:
  - `irq_o`, `as_i`, `ds_i` and `rw_i` (1 = read) are all 1.
  - `fc_i` = 4'b0111.
  - `addr_i[19:16]` = 4'hF.
  - `addr_i[3:1]` = `level_i`.
  - All other address bits (31:20, 15:4, 0) are 1.
- R3: With `iack_strobe_i` = 1, a read with both strobes asserted is selected whatever `fc_i` and `addr_i` hold.
- R4: A cycle with `rw_i` = 0 is never answered: no termination and no data enable.
- R5: A read whose function code, type field, level or upper address bits differ from R2, with `iack_strobe_i` = 0, is not answered.
- R6: While the data enable is high, the vector appears on bits 31:24 for `port_w_i` = 0 (8-bit). It appears on bits 23:16 for `port_w_i` = 1 (16-bit), and on bits 7:0 for `port_w_i` = 2 or 3 (32-bit). All other bits are 0.
- R7: With `has_vec_i` = 1, termination drives `dsack_o` (bit 0 = DSACK0, bit 1 = DSACK1, 1 = asserted) as 2'b01 for 8-bit, 2'b10 for 16-bit and 2'b11 for 32-bit, with `avec_o` = 0.
- R8: With `has_vec_i` = 0, termination drives `avec_o` = 1 and `dsack_o` = 0, and `data_oe_o` stays 0 for the whole cycle.
- R9: If the clock edge that first samples a selected cycle is edge k, `term_oe_o` is 0 after edges k..k+W and 1 after edge k+W+1, where W = `wait_i`. `data_oe_o` is high from edge k when a vector is supplied.
- R10: After termination, the first edge that samples both `as_i` and `ds_i` low drops `term_oe_o`, `data_oe_o`, `dsack_o`, `avec_o` and `irq_o` to 0.
- R11: With no request pending, an otherwise matching acknowledge is not answered.
- R12: Whenever `data_oe_o` is 0, `data_o` is 0. Whenever `term_oe_o` is 0, `dsack_o` and `avec_o` are 0.
- R13: If both strobes are not asserted together before termination, the block abandons the cycle without terminating, and `irq_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raise_i | input | 1 | Pulse that sets the pending request |
| level_i | input | 3 | Configured interrupt level, 1 to 7 |
| port_w_i | input | 2 | Port width: 0 = 8-bit, 1 = 16-bit, 2/3 = 32-bit |
| has_vec_i | input | 1 | 1 = supply vector, 0 = request autovector |
| vector_i | input | 8 | Vector number |
| wait_i | input | 4 | Wait clocks before termination |
| fc_i | input | 4 | Function code |
| addr_i | input | 32 | Address bus |
| as_i | input | 1 | Address strobe, 1 = asserted |
| ds_i | input | 1 | Data strobe, 1 = asserted |
| rw_i | input | 1 | 1 = read, 0 = write |
| iack_strobe_i | input | 1 | Dedicated acknowledge strobe for this level, 1 = asserted |
| irq_o | output | 1 | Interrupt request, 1 = requesting |
| data_o | output | 32 | Data bus out |
| data_oe_o | output | 1 | Data bus drive enable |
| dsack_o | output | 2 | Size acknowledge, bit 1 = DSACK1, bit 0 = DSACK0 |
| avec_o | output | 1 | Autovector request |
| term_oe_o | output | 1 | Enable for the termination outputs |

## Verification
The assertions assume a well-behaved host. Configuration inputs do not change while a cycle is in progress, and `rw_i` does not change while both strobes are asserted. Level 0 is never configured. The bench keeps to these assumptions in every test. It changes configuration only between cycles, holds the direction bit fixed from strobe assertion to negation, and draws random levels from 1 to 7. Random tests mix addresses that are correct with addresses corrupted in one field. This covers both the hit and the miss decisions.

// File: rtl/iack_pkg.sv
package iack_pkg;
  parameter int unsigned DATA_W = 32;
  parameter int unsigned ADDR_W = 32;
  parameter int unsigned VEC_W  = 8;
  parameter int unsigned LVL_W  = 3;
  localparam logic [3:0] FC_CPU   = 4'b0111;
  localparam logic [3:0] TYPE_ACK = 4'hF;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_TERM = 2'd2
  } seq_state_e;

  function automatic logic [1:0] size_ack(input logic [1:0] pw);
    case (pw)
      2'd0:    size_ack = 2'b01;
      2'd1:    size_ack = 2'b10;
      default: size_ack = 2'b11;
    endcase
  endfunction
endpackage

// File: rtl/iack_match.sv
module iack_match
  import iack_pkg::*;
(
  input  logic [3:0]        fc_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LVL_W-1:0]  level_i,
  input  logic              iack_strobe_i,
  output logic              hit_o
);
  logic addr_hit;
  always_comb begin
    addr_hit = (fc_i == FC_CPU) &&
               (addr_i[19:16] == TYPE_ACK) &&
               (addr_i[3:1] == level_i) &&
               (&addr_i[ADDR_W-1:20]) &&
               (&addr_i[15:4]) &&
               addr_i[0];
    hit_o = addr_hit || iack_strobe_i;
  end
endmodule

// File: rtl/iack_seq.sv
module iack_seq
  import iack_pkg::*;
#(
  parameter int unsigned WAIT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              strobes_on_i,
  input  logic              strobes_off_i,
  input  logic [WAIT_W-1:0] wait_i,
  output logic              busy_o,
  output logic              term_o,
  output logic              done_o
);
  seq_state_e        state_q, state_d;
  logic [WAIT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_o  = 1'b0;
    case (state_q)
      ST_IDLE: if (sel_i) begin
        state_d = ST_WAIT;
        cnt_d   = wait_i;
      end
      ST_WAIT: begin
        if (!strobes_on_i)   state_d = ST_IDLE;   // host abandoned the cycle
        else if (cnt_q == '0) state_d = ST_TERM;
        else                  cnt_d   = cnt_q - 1'b1;
      end
      ST_TERM: if (strobes_off_i) begin
        state_d = ST_IDLE;
        done_o  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign term_o = (state_q == ST_TERM);
endmodule

// File: rtl/iack_lane.sv
module iack_lane
  import iack_pkg::*;
(
  input  logic [1:0]        port_w_i,
  input  logic              has_vec_i,
  input  logic [VEC_W-1:0]  vector_i,
  input  logic              busy_i,
  input  logic              term_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic [1:0]        dsack_o,
  output logic              avec_o,
  output logic              term_oe_o
);
  logic [DATA_W-1:0] steered;
  always_comb begin
    steered = '0;
    case (port_w_i)
      2'd0:    steered[DATA_W-1 -: VEC_W]       = vector_i;
      2'd1:    steered[DATA_W-VEC_W-1 -: VEC_W] = vector_i;
      default: steered[VEC_W-1:0]               = vector_i;
    endcase
    data_oe_o = busy_i && has_vec_i;
    data_o    = data_oe_o ? steered : '0;
    term_oe_o = term_i;
    dsack_o   = (term_i && has_vec_i) ? size_ack(port_w_i) : 2'b00;
    avec_o    = term_i && !has_vec_i;
  end
endmodule

// File: rtl/iack_responder.sv
module iack_responder
  import iack_pkg::*;
#(
  parameter int unsigned WAIT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              raise_i,
  input  logic [2:0]        level_i,
  input  logic [1:0]        port_w_i,
  input  logic              has_vec_i,
  input  logic [7:0]        vector_i,
  input  logic [WAIT_W-1:0] wait_i,
  input  logic [3:0]        fc_i,
  input  logic [31:0]       addr_i,
  input  logic              as_i,
  input  logic              ds_i,
  input  logic              rw_i,
  input  logic              iack_strobe_i,
  output logic              irq_o,
  output logic [31:0]       data_o,
  output logic              data_oe_o,
  output logic [1:0]        dsack_o,
  output logic              avec_o,
  output logic              term_oe_o
);
  logic pend_q, hit, sel, busy, term, done;

  iack_match u_match (
    .fc_i(fc_i), .addr_i(addr_i), .level_i(level_i),
    .iack_strobe_i(iack_strobe_i), .hit_o(hit)
  );

  assign sel = pend_q && as_i && ds_i && rw_i && hit;

  iack_seq #(.WAIT_W(WAIT_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel),
    .strobes_on_i(as_i && ds_i), .strobes_off_i(!as_i && !ds_i),
    .wait_i(wait_i), .busy_o(busy), .term_o(term), .done_o(done)
  );

  iack_lane u_lane (
    .port_w_i(port_w_i), .has_vec_i(has_vec_i), .vector_i(vector_i),
    .busy_i(busy), .term_i(term), .data_o(data_o), .data_oe_o(data_oe_o),
    .dsack_o(dsack_o), .avec_o(avec_o), .term_oe_o(term_oe_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= raise_i || (pend_q && !done);
  end

  assign irq_o = pend_q;
endmodule

// File: rtl/iack_responder_chk.sv
module iack_responder_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        raise_i,
  input logic        as_i,
  input logic        ds_i,
  input logic        rw_i,
  input logic        has_vec_i,
  input logic [1:0]  port_w_i,
  input logic        irq_o,
  input logic [31:0] data_o,
  input logic        data_oe_o,
  input logic [1:0]  dsack_o,
  input logic        avec_o,
  input logic        term_oe_o
);
  assert_raise_sets_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raise_i |=> irq_o);
  assert_read_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (term_oe_o && as_i && ds_i) |-> rw_i);
  assert_lane8_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && port_w_i == 2'd0) |-> (data_o[23:0] == 24'd0));
  assert_lane16_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && port_w_i == 2'd1) |-> (data_o[31:24] == 8'd0 && data_o[15:0] == 16'd0));
  assert_one_kind_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_oe_o |-> (avec_o ^ (dsack_o != 2'b00)));
  assert_avec_no_data_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (term_oe_o && !has_vec_i) |-> (avec_o && !data_oe_o));
  assert_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (term_oe_o && !as_i && !ds_i) |=> (!term_oe_o && !data_oe_o && !irq_o));
  assert_irq_fall_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(term_oe_o));
  assert_idle_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !term_oe_o |-> (dsack_o == 2'b00 && !avec_o));
  assert_data_zero_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> (data_o == 32'd0));
endmodule

bind iack_responder iack_responder_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .raise_i(raise_i), .as_i(as_i), .ds_i(ds_i),
  .rw_i(rw_i), .has_vec_i(has_vec_i), .port_w_i(port_w_i), .irq_o(irq_o),
  .data_o(data_o), .data_oe_o(data_oe_o), .dsack_o(dsack_o), .avec_o(avec_o),
  .term_oe_o(term_oe_o)
);

// File: tb/tb_iack_responder.sv
module tb_iack_responder;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic raise_i = 0, has_vec_i = 0, as_i = 0, ds_i = 0, rw_i = 0, iack_strobe_i = 0;
  logic [2:0] level_i = 3'd1;
  logic [1:0] port_w_i = 0;
  logic [7:0] vector_i = 0;
  logic [3:0] wait_i = 0, fc_i = 0;
  logic [31:0] addr_i = 0;
  logic irq_o, data_oe_o, avec_o, term_oe_o;
  logic [31:0] data_o;
  logic [1:0] dsack_o;
  int tests = 0, fails = 0;
  bit exp_pend = 0;

  always #5 clk_i = ~clk_i;

  iack_responder dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ack_addr(input logic [2:0] lvl);
    ack_addr = 32'hFFFF_FFFF;
    ack_addr[3:1] = lvl;
  endfunction

  function automatic logic [31:0] exp_data(input logic [1:0] pw, input logic [7:0] v);
    case (pw)
      2'd0:    exp_data = {v, 24'd0};
      2'd1:    exp_data = {8'd0, v, 16'd0};
      default: exp_data = {24'd0, v};
    endcase
  endfunction

  function automatic logic [1:0] exp_ack(input logic [1:0] pw);
    exp_ack = (pw == 2'd0) ? 2'b01 : (pw == 2'd1) ? 2'b10 : 2'b11;
  endfunction

  task automatic raise();
    @(negedge clk_i) raise_i = 1;
    @(posedge clk_i);
    @(negedge clk_i) raise_i = 0;
    exp_pend = 1;
    chk("R1 irq after raise", irq_o, 1);
  endtask

  // full bus cycle; hit = expected selection, abort_at >= 0 negates strobes early
  task automatic bus_cycle(input logic [3:0] fc, input logic [31:0] a, input logic rw,
                           input logic strb, input bit hit, input int abort_at);
    int w = int'(wait_i);
    @(negedge clk_i);
    fc_i = fc; addr_i = a; rw_i = rw; iack_strobe_i = strb; as_i = 1; ds_i = 1;
    if (!hit) begin
      for (int i = 0; i < w + 3; i++) begin
        @(posedge clk_i); @(negedge clk_i);
        chk("R4/R5/R11 no term on miss", term_oe_o, 0);
        chk("R4/R5/R11 no data on miss", data_oe_o, 0);
      end
      as_i = 0; ds_i = 0; iack_strobe_i = 0;
      @(posedge clk_i); @(negedge clk_i);
      chk("R1 irq held after miss", irq_o, exp_pend);
      return;
    end
    for (int i = 0; i <= w; i++) begin
      @(posedge clk_i); @(negedge clk_i);
      chk("R9 no early term", term_oe_o, 0);
      chk("R9 data enable in wait", data_oe_o, has_vec_i);
      chk("R12 data zero or vector", data_o, has_vec_i ? exp_data(port_w_i, vector_i) : 32'd0);
      if (i == abort_at) begin
        as_i = 0; ds_i = 0; iack_strobe_i = 0;
        repeat (w + 2) begin
          @(posedge clk_i); @(negedge clk_i);
          chk("R13 no term after abort", term_oe_o, 0);
        end
        chk("R13 irq kept after abort", irq_o, 1);
        return;
      end
    end
    @(posedge clk_i); @(negedge clk_i);
    chk("R9 term at W+1", term_oe_o, 1);
    if (has_vec_i) begin
      chk("R7 dsack encoding", dsack_o, exp_ack(port_w_i));
      chk("R7 no avec", avec_o, 0);
      chk("R6 vector lane", data_o, exp_data(port_w_i, vector_i));
    end else begin
      chk("R8 avec", avec_o, 1);
      chk("R8 no dsack", dsack_o, 0);
      chk("R8 no data", data_oe_o, 0);
    end
    @(posedge clk_i); @(negedge clk_i);
    chk("R10 term held until strobes negate", term_oe_o, 1);
    chk("R1 irq held during term", irq_o, 1);
    as_i = 0; ds_i = 0; iack_strobe_i = 0;
    @(posedge clk_i); @(negedge clk_i);
    exp_pend = 0;
    chk("R10 term released", term_oe_o, 0);
    chk("R10 data released", data_oe_o, 0);
    chk("R12 dsack zero", dsack_o, 0);
    chk("R12 avec zero", avec_o, 0);
    chk("R10 irq cleared", irq_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7315));
    repeat (2) @(negedge clk_i);
    chk("R12 reset term_oe", term_oe_o, 0);
    chk("R12 reset data", data_o, 0);
    chk("R1 reset irq", irq_o, 0);
    rst_ni = 1;

    // directed: address path, 8-bit, no wait
    level_i = 3'd5; port_w_i = 0; has_vec_i = 1; vector_i = 8'hA7; wait_i = 0;
    raise();
    bus_cycle(4'b0111, ack_addr(3'd5), 1, 0, 1, -1);  // R2
    // R11: nothing pending
    bus_cycle(4'b0111, ack_addr(3'd5), 1, 0, 0, -1);
    // R3: dedicated strobe with junk address, 16-bit, wait 3
    port_w_i = 1; wait_i = 3; vector_i = 8'h3C;
    raise();
    bus_cycle(4'b0000, 32'h1234_5678, 1, 1, 1, -1);
    // R4: write ignored, then finish with read
    raise();
    bus_cycle(4'b0111, ack_addr(3'd5), 0, 0, 0, -1);
    // R13 abort, then R8 autovector completion
    wait_i = 5;
    bus_cycle(4'b0111, ack_addr(3'd5), 1, 0, 1, 2);
    has_vec_i = 0; wait_i = 1;
    bus_cycle(4'b0111, ack_addr(3'd5), 1, 0, 1, -1);

    // random mix
    for (int n = 0; n < 120; n++) begin
      logic [31:0] a;
      logic [3:0] fc;
      logic strb;
      bit hit;
      int corrupt;
      level_i   = 3'($urandom_range(7, 1));
      port_w_i  = 2'($urandom_range(3, 0));
      has_vec_i = 1'($urandom_range(1, 0));
      vector_i  = 8'($urandom);
      wait_i    = 4'($urandom_range(6, 0));
      if (!exp_pend && $urandom_range(3, 0) != 0) raise();
      a = ack_addr(level_i); fc = 4'b0111;
      strb = ($urandom_range(4, 0) == 0);
      corrupt = strb ? 0 : $urandom_range(4, 0);
      case (corrupt)
        1: fc = fc ^ 4'(1 << $urandom_range(3, 0));          // R5 bad fc
        2: a[16 + $urandom_range(3, 0)] = 1'b0;              // R5 bad type
        3: a[3:1] = level_i + 3'($urandom_range(7, 1));      // R5 bad level
        4: a[$urandom_range(31, 20)] = 1'b0;                 // R5 bad upper bit
        default: ;
      endcase
      hit = exp_pend && (corrupt == 0);
      bus_cycle(fc, a, 1, strb, hit, -1);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule